// File: doc/BRIEF.md
# Running-Sum Boxcar Slicer

This block cleans an oversampled one-bit line before it reaches an edge-timing Manchester decoder. Each accepted sample counts as +1 when the line is high and -1 when it is low. The block sums these values over a window of `WIN_LEN` samples. That window is set to half a bit period, so it matches one short Manchester pulse. Each posted sum is then sliced back to a single bit.

A parameter `MODE` selects one of three ways to form the sum:

- **MODE 0 (default).** A free-running up/down counter whose value at one window end is subtracted from its value at the next, with wrap-around allowed. No samples are stored.
- **MODE 1.** The window's samples are shifted into a `WIN_LEN`-bit register, and that byte indexes a computed table of signed counts. MODE 0 and MODE 1 post identical results.
- **MODE 2.** A sliding window that posts a fresh sum on every sample once the window has filled. It adds the new sample and removes the one leaving a shift register.

A sample is taken only on a clock where `smp_en` is high. The posted sum is held on `win_sum`, and `win_done` marks the cycle it appears. The sliced bit follows the sign of the sum. A zero sum, which is what a window straddling an edge gives, leaves the output bit unchanged.

Top module: `boxcar_slicer`

## Requirements
- R1: A synchronous active-low reset sets `bit_out` to 1 (idle-high line), `win_sum` to 0 and `win_done` to 0.
- R2: On a clock where `smp_en` is low, `raw_bit` is ignored. It changes no later sum and no output.
- R3: In MODE 0, every `WIN_LEN`-th accepted sample after reset ends a window. On the clock edge that takes that sample, `win_sum` becomes the number of 1 samples minus the number of 0 samples in the window, in two's complement on `$clog2(WIN_LEN)+2` bits, and `win_done` is high for the following cycle only.
- R4: Long runs of a single level, which wrap the internal counter many times, still give window sums of exactly +`WIN_LEN` or -`WIN_LEN`.
- R5: MODE 1 posts exactly the same `win_sum`, `win_done` and `bit_out` sequence as MODE 0 for any input.
- R6: In MODE 2, every accepted sample from the `WIN_LEN`-th one after reset posts the sum of the latest `WIN_LEN` samples, with `win_done` high for one cycle.
- R7: No sum is posted before `WIN_LEN` samples have been accepted since reset. Until then, `bit_out` stays 1.
- R8: When a sum is posted, `bit_out` becomes 1 if the sum is positive and 0 if it is negative. Between posts, `bit_out` does not change.
- R9: A posted sum of zero leaves `bit_out` at its previous value.
- R10: `win_sum` holds its value in every cycle where `win_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_en | input | 1 | Sample strobe; `raw_bit` is taken on this clock |
| raw_bit | input | 1 | Oversampled line level |
| win_sum | output | $clog2(WIN_LEN)+2 | Signed window sum, held between posts |
| win_done | output | 1 | One-cycle mark that a new sum was posted |
| bit_out | output | 1 | Sliced output bit |

## Verification
The three variants run side by side on the same inputs. Their behaviour is checked against a sample-history model.

Long constant runs show whether the counter difference survives wrap-around. Alternating half-bit pulses that line up with the window give full-scale sums that drive the slicer both ways. The same pulses shifted by half a window produce zero sums, which show whether the output holds. Pulses with a single flipped sample give reduced but non-zero sums.

Random levels with gaps in `smp_en` separate correct sample counting from counting of clocks. A reset in mid-run confirms that the first window is not posted early.

// File: rtl/bxf_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the boxcar slicer.
// Assumes: nothing beyond a standard elaborator.
package bxf_pkg;

    localparam int MODE_DIFF  = 0;  // counter difference per block window
    localparam int MODE_LUT   = 1;  // shift register mapped through a table
    localparam int MODE_SLIDE = 2;  // sum updated on every sample

    // Number of set bits among the low n bits of v.
    function automatic int ones_of(input int v, input int n);
        int c;
        c = 0;
        for (int i = 0; i < n; i++) begin
            c += (v >> i) & 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/bxf_win_phase.sv
`timescale 1ns/1ps
// Counts accepted samples and flags the sample that ends a window.
// Block mode wraps after WIN_LEN samples. Sliding mode stops at the last
// position, so every sample after the first WIN_LEN ends a window.
// Assumes: WIN_LEN >= 2.
module bxf_win_phase #(
    parameter int WIN_LEN = 8,
    parameter bit SLIDING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    output logic win_end
);
    localparam int              PH_W = $clog2(WIN_LEN);
    localparam logic [PH_W-1:0] LAST = PH_W'(WIN_LEN - 1);

    logic [PH_W-1:0] ph;
    logic            at_last;

    assign at_last = (ph == LAST);
    assign win_end = smp_en && at_last;

    // Advance the sample position on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (smp_en) begin
            if (!at_last)      ph <= ph + PH_W'(1);
            else if (!SLIDING) ph <= '0;
        end
    end
endmodule

// File: rtl/bxf_diff_sum.sv
`timescale 1ns/1ps
// Up/down counter window sum. The counter steps +1 on a high sample and
// -1 on a low one and wraps freely. The window sum is the difference
// against the snapshot taken at the previous window end.
// Assumes: SUM_W is large enough that one window cannot wrap the counter
// more than once (|sum| < 2**(SUM_W-1)).
module bxf_diff_sum #(
    parameter int SUM_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    raw_bit,
    input  logic                    win_end,
    output logic signed [SUM_W-1:0] sum_nx
);
    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] snap;
    logic [SUM_W-1:0] acc_nx;

    assign acc_nx = raw_bit ? acc + SUM_W'(1) : acc - SUM_W'(1);
    assign sum_nx = signed'(acc_nx - snap);

    // Running level counter, stepped on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (smp_en) acc <= acc_nx;
    end

    // Capture the counter at each window end for the next difference.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap <= '0;
        else if (win_end) snap <= acc_nx;
    end
endmodule

// File: rtl/bxf_lut_sum.sv
`timescale 1ns/1ps
// Table window sum. The last WIN_LEN samples sit in a shift register.
// Its value indexes a table of signed counts that is computed at
// elaboration.
// Assumes: WIN_LEN small enough for a 2**WIN_LEN table (8 gives 256).
module bxf_lut_sum #(
    parameter int WIN_LEN = 8,
    parameter int SUM_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    raw_bit,
    output logic signed [SUM_W-1:0] sum_nx
);
    localparam int TBL_N = 1 << WIN_LEN;

    logic [WIN_LEN-1:0]      sh;
    logic [WIN_LEN-1:0]      sh_nx;
    logic signed [SUM_W-1:0] tbl [TBL_N];

    assign sh_nx = {sh[WIN_LEN-2:0], raw_bit};

    // Each entry is (ones - zeros) for its sample pattern.
    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        localparam int ONES = bxf_pkg::ones_of(g, WIN_LEN);
        assign tbl[g] = SUM_W'(2 * ONES - WIN_LEN);
    end

    assign sum_nx = tbl[sh_nx];

    // Shift in each accepted sample; idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      sh <= '1;
        else if (smp_en) sh <= sh_nx;
    end
endmodule

// File: rtl/bxf_slide_sum.sv
`timescale 1ns/1ps
// Sliding window sum. On each sample the sum gains the new sample's +/-1
// and loses the +/-1 of the sample leaving the window.
// Assumes: the history starts as an idle-high window (sum = +WIN_LEN).
module bxf_slide_sum #(
    parameter int WIN_LEN = 8,
    parameter int SUM_W   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    raw_bit,
    output logic signed [SUM_W-1:0] sum_nx
);
    localparam logic signed [SUM_W-1:0] TWO  = SUM_W'(2);
    localparam logic signed [SUM_W-1:0] FULL = SUM_W'(WIN_LEN);

    logic [WIN_LEN-1:0]      sh;
    logic signed [SUM_W-1:0] sum;
    logic                    leave;

    assign leave = sh[WIN_LEN-1];

    // Net change: zero when the entering and leaving samples match.
    always_comb begin
        sum_nx = sum;
        if (raw_bit && !leave)      sum_nx = sum + TWO;
        else if (!raw_bit && leave) sum_nx = sum - TWO;
    end

    // Keep the history and the running sum in step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '1;
            sum <= FULL;
        end else if (smp_en) begin
            sh  <= {sh[WIN_LEN-2:0], raw_bit};
            sum <= sum_nx;
        end
    end
endmodule

// File: rtl/bxf_slicer.sv
`timescale 1ns/1ps
// Re-quantises a posted sum to one bit by its sign. A zero sum keeps the
// previous bit.
// Assumes: sum_in is valid only when post is high.
module bxf_slicer #(
    parameter int SUM_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    post,
    input  logic signed [SUM_W-1:0] sum_in,
    output logic                    bit_out
);
    // Follow the sign of each non-zero posted sum.
    always_ff @(posedge clk) begin
        if (!rst_n)                         bit_out <= 1'b1;
        else if (post && (sum_in != '0))    bit_out <= ~sum_in[SUM_W-1];
    end
endmodule

// File: rtl/boxcar_slicer.sv
`timescale 1ns/1ps
// Boxcar filter over WIN_LEN one-bit samples with a sign slicer.
// MODE selects the sum engine: counter difference, table lookup or
// sliding. The sum is posted on the edge that takes the window's last
// sample.
// Assumes: WIN_LEN >= 2. MODE_LUT needs a small WIN_LEN.
module boxcar_slicer #(
    parameter  int WIN_LEN = 8,
    parameter  int MODE    = bxf_pkg::MODE_DIFF,
    localparam int SUM_W   = $clog2(WIN_LEN) + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    raw_bit,
    output logic signed [SUM_W-1:0] win_sum,
    output logic                    win_done,
    output logic                    bit_out
);
    localparam bit SLIDING = (MODE == bxf_pkg::MODE_SLIDE);

    logic                    win_end;
    logic signed [SUM_W-1:0] eng_sum;

    bxf_win_phase #(.WIN_LEN(WIN_LEN), .SLIDING(SLIDING)) phase_i (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .win_end(win_end)
    );

    if (MODE == bxf_pkg::MODE_LUT) begin : g_lut
        bxf_lut_sum #(.WIN_LEN(WIN_LEN), .SUM_W(SUM_W)) eng_i (
            .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
            .raw_bit(raw_bit), .sum_nx(eng_sum)
        );
    end else if (MODE == bxf_pkg::MODE_SLIDE) begin : g_slide
        bxf_slide_sum #(.WIN_LEN(WIN_LEN), .SUM_W(SUM_W)) eng_i (
            .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
            .raw_bit(raw_bit), .sum_nx(eng_sum)
        );
    end else begin : g_diff
        bxf_diff_sum #(.SUM_W(SUM_W)) eng_i (
            .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
            .raw_bit(raw_bit), .win_end(win_end), .sum_nx(eng_sum)
        );
    end

    // Hold the latest posted sum and mark the post for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_sum  <= '0;
            win_done <= 1'b0;
        end else begin
            win_done <= win_end;
            if (win_end) win_sum <= eng_sum;
        end
    end

    bxf_slicer #(.SUM_W(SUM_W)) slice_i (
        .clk(clk), .rst_n(rst_n), .post(win_end),
        .sum_in(eng_sum), .bit_out(bit_out)
    );
endmodule

// File: rtl/boxcar_slicer_chk.sv
`timescale 1ns/1ps
// Port-level checks for boxcar_slicer, bound into every instance.
module boxcar_slicer_chk #(
    parameter int WIN_LEN = 8,
    parameter int SUM_W   = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_en,
    input logic                    win_done,
    input logic                    bit_out,
    input logic signed [SUM_W-1:0] win_sum
);
    int seen;

    // Count accepted samples since reset, saturating at WIN_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n)                         seen <= 0;
        else if (smp_en && seen < WIN_LEN)  seen <= seen + 1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (bit_out && win_sum == '0 && !win_done));

    // R3
    post_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(smp_en));

    // R3
    sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (int'(win_sum) <= WIN_LEN && int'(win_sum) >= -WIN_LEN
                      && win_sum[0] == 1'(WIN_LEN % 2)));

    // R7
    no_early_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> seen >= WIN_LEN);

    // R8
    positive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && win_sum > 0) |-> bit_out);

    // R8
    negative_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && win_sum < 0) |-> !bit_out);

    // R8
    bit_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(bit_out));

    // R9
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && win_sum == '0) |-> $stable(bit_out));

    // R10
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(win_sum));
endmodule

bind boxcar_slicer boxcar_slicer_chk #(.WIN_LEN(WIN_LEN), .SUM_W(SUM_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
    .win_done(win_done), .bit_out(bit_out), .win_sum(win_sum)
);

// File: tb/boxcar_slicer_tb_top.sv
`timescale 1ns/1ps
// Runs the three sum variants side by side against a sample-history model.
module boxcar_slicer_tb_top;
    localparam int WIN = 8;
    localparam int SW  = $clog2(WIN) + 2;

    logic clk = 1'b0, rst_n = 1'b0, smp_en = 1'b0, raw_bit = 1'b0;
    logic signed [SW-1:0] a_sum  [3];
    logic                 a_done [3];
    logic                 a_bit  [3];

    always #4 clk = ~clk;

    boxcar_slicer #(.WIN_LEN(WIN), .MODE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .raw_bit(raw_bit),
        .win_sum(a_sum[0]), .win_done(a_done[0]), .bit_out(a_bit[0]));
    boxcar_slicer #(.WIN_LEN(WIN), .MODE(1)) dut_lut_i (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .raw_bit(raw_bit),
        .win_sum(a_sum[1]), .win_done(a_done[1]), .bit_out(a_bit[1]));
    boxcar_slicer #(.WIN_LEN(WIN), .MODE(2)) dut_sld_i (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .raw_bit(raw_bit),
        .win_sum(a_sum[2]), .win_done(a_done[2]), .bit_out(a_bit[2]));

    int    n_chk = 0, n_fail = 0;
    string tag   = "R1";
    int    hist[$];
    int    nsamp;
    int    e_sum  [3];
    bit    e_done [3];
    bit    e_bit  [3];

    function void m_reset();
        hist.delete();
        nsamp = 0;
        for (int m = 0; m < 3; m++) begin
            e_sum[m] = 0; e_done[m] = 1'b0; e_bit[m] = 1'b1;
        end
    endfunction

    // Model the state after the coming edge.
    function void m_step(bit en, bit rb, bit rst_low);
        int s;
        bit post;
        if (rst_low) begin
            m_reset();
            return;
        end
        for (int m = 0; m < 3; m++) e_done[m] = 1'b0;
        if (!en) return;
        hist.push_back(rb ? 1 : -1);
        if (hist.size() > WIN) void'(hist.pop_front());
        nsamp++;
        s = 0;
        foreach (hist[i]) s += hist[i];
        for (int m = 0; m < 3; m++) begin
            post = (m == 2) ? (nsamp >= WIN) : (nsamp % WIN == 0);
            if (post) begin
                e_sum[m]  = s;
                e_done[m] = 1'b1;
                if (s > 0)      e_bit[m] = 1'b1;
                else if (s < 0) e_bit[m] = 1'b0;
            end
        end
    endfunction

    task automatic compare();
        string mt;
        for (int m = 0; m < 3; m++) begin
            mt = (m == 0) ? "R3" : (m == 1) ? "R5" : "R6";
            n_chk++;
            if (int'(a_sum[m]) != e_sum[m] || a_done[m] !== e_done[m] ||
                a_bit[m] !== e_bit[m]) begin
                n_fail++;
                $display("FAIL %s/%s mode%0d: sum=%0d done=%b bit=%b expected sum=%0d done=%b bit=%b",
                         tag, mt, m, a_sum[m], a_done[m], a_bit[m],
                         e_sum[m], e_done[m], e_bit[m]);
            end
        end
    endtask

    task automatic cyc_r(bit r, bit en, bit rb);
        @(negedge clk);
        compare();
        rst_n = r; smp_en = en; raw_bit = rb;
        m_step(en, rb, !r);
    endtask

    task automatic cyc(bit en, bit rb);
        cyc_r(1'b1, en, rb);
    endtask

    // One sample, then gap idle clocks with a toggling raw_bit (R2).
    task automatic samp(bit rb, int gap);
        cyc(1'b1, rb);
        repeat (gap) cyc(1'b0, 1'($urandom_range(0, 1)));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_reset();
        tag = "R1";
        repeat (3) cyc_r(1'b0, 1'b1, 1'($urandom_range(0, 1)));
        tag = "R7";
        for (int i = 0; i < 7; i++) samp(1'b0, i % 3);
        tag = "R2";
        repeat (20) cyc(1'b0, 1'($urandom_range(0, 1)));
        samp(1'b0, 0);
        tag = "R4";
        repeat (40) samp(1'b1, 0);
        repeat (40) samp(1'b0, 1);
        tag = "R8";
        repeat (6) begin
            repeat (8) samp(1'b1, 0);
            repeat (8) samp(1'b0, 0);
        end
        tag = "R9";
        repeat (4) samp(1'b1, 0);
        repeat (5) begin
            repeat (8) samp(1'b0, 0);
            repeat (8) samp(1'b1, 0);
        end
        tag = "R10";
        repeat (4) begin
            repeat (7) samp(1'b1, 1);
            samp(1'b0, 2);
        end
        tag = "R3";
        repeat (600) samp(1'($urandom_range(0, 1)), $urandom_range(0, 2));
        tag = "R1";
        repeat (2) cyc_r(1'b0, 1'b1, 1'b0);
        tag = "R7";
        for (int i = 0; i < 9; i++) samp(1'b0, 1);
        tag = "R2";
        repeat (200) samp(1'($urandom_range(0, 1)), $urandom_range(0, 3));
        cyc(1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule